// File: doc/BRIEF.md
# Power-On/Off Sequencing Controller

This block is the digital state machine that decides when a battery-powered system turns on and off. It sits in the always-powered domain, watches three wake sources and two battery comparator flags, and walks the analog rails through fixed enable and disable orders. The wake sources are a power button (active low, debounced), an alarm line and a charger comparator. The rails are a local oscillator, a bandgap, a charge pump, a regulator group and a DC/DC converter. All voltage comparisons arrive as single status bits from comparators outside the block.

Power-up enables the rails one step at a time. A step lasts `cfg_step_dly + 1` clock cycles. Partway through, the sequence checks the boot-voltage comparator. If that check fails, the sequence unwinds what it has already enabled and returns to off. While on, a shutdown request starts a timed window with the converter, reset and main clock removed, followed by the ordered teardown. A critical-battery flag instead pulls the fast-interrupt line low one step before the same teardown begins. A 3-bit mode output reports the current phase.

Top module: `pwr_seq_ctrl`

## Requirements
- R1: While reset is applied, every enable output, `on_off` and `clk_main_en` are 0. `sys_rst_n` is 0, `fiq_n` is 1 and `pwr_mode` is 0.
- R2: A button press wakes the block only after `pwr_btn_n` has stayed low for DEB_CYC synchronized cycles. A shorter low pulse leaves the block off.
- R3: A rising edge on `alarm_in` wakes the block. An alarm level that stays high causes no further wake once the block is back off.
- R4: A rising edge on `chg_above_bat` wakes the block. A charger flag that stays high causes no second wake after power-down.
- R5: Power-up follows a fixed order, with D = `cfg_step_dly` + 1. The oscillator turns on. D cycles later the bandgap turns on. 2·D cycles after that the charge pump turns on, the middle step being the battery check. Each of these then follows D cycles apart, in order: the regulator group together with the DC/DC converter, `on_off`, reset release, and the main clock. D cycles after the main clock, the mode reads on.
- R6: If `bat_above_boot` is 0 at the end of the check step, the bandgap turns off. D cycles later the oscillator turns off and the block is off. The charge pump and later stages are never enabled.
- R7: A shutdown request while on sets the mode to powering down. In that same cycle `dcdc_en`, `sys_rst_n` and `clk_main_en` drop. `on_off` falls OFF_WIN_CYC cycles later. The regulator group and charge pump, then the bandgap, then the oscillator follow D cycles apart.
- R8: A critical-battery flag while on drives `fiq_n` low first. The R7 teardown starts D cycles later. `fiq_n` returns high in the cycle the oscillator turns off.
- R9: Wake events that arrive while the block is not off are dropped. They neither restart the sequence nor cause a wake later.
- R10: `pwr_mode` encodes off = 0, powering up (including an aborted check) = 1, on = 2, powering down = 3, emergency = 4. An emergency teardown reads 4 throughout.
- R11: When the critical-battery flag and a shutdown request arrive in the same on cycle, the emergency path is taken.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Always-on clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| pwr_btn_n | input | 1 | Power button, low when pressed |
| alarm_in | input | 1 | Alarm wake request, rising edge |
| chg_above_bat | input | 1 | Comparator: charger exceeds battery by the margin |
| bat_above_boot | input | 1 | Comparator: battery above the boot threshold |
| bat_below_crit | input | 1 | Comparator: battery below the critical threshold |
| off_req | input | 1 | Long-press or software shutdown request |
| cfg_step_dly | input | DLY_W | Extra cycles per sequence step |
| osc_en | output | 1 | Local oscillator enable |
| bandgap_en | output | 1 | Bandgap reference enable |
| chg_pump_en | output | 1 | Charge pump enable |
| ldo_en | output | 1 | Regulator group enable |
| dcdc_en | output | 1 | DC/DC converter enable |
| on_off | output | 1 | System-on status |
| sys_rst_n | output | 1 | Active-low system reset |
| fiq_n | output | 1 | Active-low fast interrupt |
| clk_main_en | output | 1 | Main clock oscillator enable |
| pwr_mode | output | 3 | Phase code per R10 |

## Verification
The bench sweeps the step delay over 0, 1, 2, 3, 5 and 7 and rotates the wake source among button, alarm and charger. It records the cycle of every output edge and compares each gap with D or OFF_WIN_CYC, which separates an off-by-one in the step timer from a wrong step order. Normal and emergency teardowns alternate across the sweep, so the R8 fiq timing is compared against the plain R7 path. Separate patterns cover a too-short button press, a failed boot check at two delays, wake sources held high or retriggered during power-up and while on, and a simultaneous shutdown and critical-battery request.

// File: rtl/pwr_seq_pkg.sv
package pwr_seq_pkg;

  typedef enum logic [3:0] {
    ST_OFF,
    ST_UP_OSC,
    ST_UP_BG,
    ST_UP_CHK,
    ST_UP_CP,
    ST_UP_REG,
    ST_UP_ONOFF,
    ST_UP_RST,
    ST_UP_CLK,
    ST_ON,
    ST_EMG,
    ST_DN_WIN,
    ST_DN_ONOFF,
    ST_DN_REG,
    ST_DN_BG,
    ST_ABORT
  } seq_st_e;

  typedef enum logic [2:0] {
    MODE_OFF  = 3'd0,
    MODE_UP   = 3'd1,
    MODE_ON   = 3'd2,
    MODE_DOWN = 3'd3,
    MODE_EMG  = 3'd4
  } pwr_mode_e;

  typedef struct packed {
    logic osc;
    logic bg;
    logic cp;
    logic reg_on;
    logic dcdc;
    logic on_off;
    logic rst_rel;
    logic clk_en;
  } rail_t;

  // Rail pattern held during each sequencer state
  function automatic rail_t rails_of(seq_st_e s);
    rail_t r;
    r = '0;
    case (s)
      ST_UP_OSC, ST_ABORT, ST_DN_BG: r.osc = 1'b1;
      ST_UP_BG, ST_UP_CHK, ST_DN_REG: begin
        r.osc = 1'b1; r.bg = 1'b1;
      end
      ST_UP_CP: begin
        r.osc = 1'b1; r.bg = 1'b1; r.cp = 1'b1;
      end
      ST_UP_REG: begin
        r = 8'b1111_1000;
      end
      ST_UP_ONOFF: r = 8'b1111_1100;
      ST_UP_RST:   r = 8'b1111_1110;
      ST_UP_CLK, ST_ON, ST_EMG: r = 8'b1111_1111;
      ST_DN_WIN:   r = 8'b1111_0100;
      ST_DN_ONOFF: r = 8'b1111_0000;
      default:     r = '0;
    endcase
    return r;
  endfunction

  function automatic pwr_mode_e mode_of(seq_st_e s, logic emg);
    case (s)
      ST_OFF: return MODE_OFF;
      ST_ON:  return MODE_ON;
      ST_EMG: return MODE_EMG;
      ST_DN_WIN, ST_DN_ONOFF, ST_DN_REG, ST_DN_BG:
        return emg ? MODE_EMG : MODE_DOWN;
      default: return MODE_UP;
    endcase
  endfunction

endpackage

// File: rtl/pwr_wake_det.sv
module pwr_wake_det #(
  parameter int DEB_CYC  = 1_500_000,
  parameter int SYNC_STG = 2
) (
  input  logic clk,
  input  logic rst_n,
  input  logic btn_n,
  input  logic alarm,
  input  logic chg_gt,
  output logic btn_wake,
  output logic alm_wake,
  output logic chg_wake
);
  localparam int DEB_W = $clog2(DEB_CYC + 1);
  localparam logic [2:0] IDLE_V = 3'b001;

  logic [2:0] raw;
  logic [2:0] sync_v;
  logic [2:0] prev_q;
  logic [DEB_W-1:0] low_cnt;

  assign raw = {chg_gt, alarm, btn_n};

  for (genvar i = 0; i < 3; i++) begin : g_sync
    logic [SYNC_STG-1:0] sh;
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) sh <= {SYNC_STG{IDLE_V[i]}};
      else        sh <= {sh[SYNC_STG-2:0], raw[i]};
    end
    assign sync_v[i] = sh[SYNC_STG-1];
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      prev_q  <= IDLE_V;
      low_cnt <= '0;
    end else begin
      prev_q <= sync_v;
      if (sync_v[0])                        low_cnt <= '0;
      else if (low_cnt != DEB_W'(DEB_CYC))  low_cnt <= low_cnt + 1'b1;
    end
  end

  assign btn_wake = !sync_v[0] && (low_cnt == DEB_W'(DEB_CYC - 1));
  assign alm_wake = sync_v[1] && !prev_q[1];
  assign chg_wake = sync_v[2] && !prev_q[2];

endmodule

// File: rtl/pwr_step_tmr.sv
module pwr_step_tmr #(
  parameter int W = 16
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         clr,
  input  logic [W-1:0] lim,
  output logic         done
);
  logic [W-1:0] cnt;

  assign done = (cnt >= lim);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)     cnt <= '0;
    else if (clr)   cnt <= '0;
    else if (!done) cnt <= cnt + 1'b1;
  end
endmodule

// File: rtl/pwr_seq_fsm.sv
module pwr_seq_fsm
  import pwr_seq_pkg::*;
(
  input  logic    clk,
  input  logic    rst_n,
  input  logic    wake,
  input  logic    bat_ok,
  input  logic    bat_low,
  input  logic    off_req,
  input  logic    tmr_done,
  output seq_st_e st,
  output logic    step_clr,
  output logic    emg,
  output logic    chk_fail
);
  seq_st_e nxt;

  assign chk_fail = (st == ST_UP_CHK) && tmr_done && !bat_ok;
  assign step_clr = (nxt != st);

  always_comb begin
    nxt = st;
    case (st)
      ST_OFF:      if (wake)     nxt = ST_UP_OSC;
      ST_UP_OSC:   if (tmr_done) nxt = ST_UP_BG;
      ST_UP_BG:    if (tmr_done) nxt = ST_UP_CHK;
      ST_UP_CHK:   if (tmr_done) nxt = bat_ok ? ST_UP_CP : ST_ABORT;
      ST_UP_CP:    if (tmr_done) nxt = ST_UP_REG;
      ST_UP_REG:   if (tmr_done) nxt = ST_UP_ONOFF;
      ST_UP_ONOFF: if (tmr_done) nxt = ST_UP_RST;
      ST_UP_RST:   if (tmr_done) nxt = ST_UP_CLK;
      ST_UP_CLK:   if (tmr_done) nxt = ST_ON;
      ST_ON: begin
        if (bat_low)      nxt = ST_EMG;
        else if (off_req) nxt = ST_DN_WIN;
      end
      ST_EMG:      if (tmr_done) nxt = ST_DN_WIN;
      ST_DN_WIN:   if (tmr_done) nxt = ST_DN_ONOFF;
      ST_DN_ONOFF: if (tmr_done) nxt = ST_DN_REG;
      ST_DN_REG:   if (tmr_done) nxt = ST_DN_BG;
      ST_DN_BG:    if (tmr_done) nxt = ST_OFF;
      ST_ABORT:    if (tmr_done) nxt = ST_OFF;
      default:                   nxt = ST_OFF;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st  <= ST_OFF;
      emg <= 1'b0;
    end else begin
      st <= nxt;
      if (nxt == ST_OFF)      emg <= 1'b0;
      else if (nxt == ST_EMG) emg <= 1'b1;
    end
  end
endmodule

// File: rtl/pwr_seq_ctrl.sv
module pwr_seq_ctrl
  import pwr_seq_pkg::*;
#(
  parameter int DLY_W       = 8,
  parameter int TMR_W       = 16,
  parameter int DEB_CYC     = 1_500_000,
  parameter int OFF_WIN_CYC = 7500,
  parameter int SYNC_STG    = 2
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             pwr_btn_n,
  input  logic             alarm_in,
  input  logic             chg_above_bat,
  input  logic             bat_above_boot,
  input  logic             bat_below_crit,
  input  logic             off_req,
  input  logic [DLY_W-1:0] cfg_step_dly,
  output logic             osc_en,
  output logic             bandgap_en,
  output logic             chg_pump_en,
  output logic             ldo_en,
  output logic             dcdc_en,
  output logic             on_off,
  output logic             sys_rst_n,
  output logic             fiq_n,
  output logic             clk_main_en,
  output logic [2:0]       pwr_mode
);
  localparam logic [TMR_W-1:0] WIN_LIM = TMR_W'(OFF_WIN_CYC - 1);

  // Named internal events
  logic       btn_wake, alm_wake, chg_wake, wake_any;
  logic       tmr_done, step_clr, emg, chk_fail;
  logic [TMR_W-1:0] tmr_lim;
  seq_st_e    st;
  rail_t      rails;

  pwr_wake_det #(
    .DEB_CYC (DEB_CYC),
    .SYNC_STG(SYNC_STG)
  ) u_wake (
    .clk     (clk),
    .rst_n   (rst_n),
    .btn_n   (pwr_btn_n),
    .alarm   (alarm_in),
    .chg_gt  (chg_above_bat),
    .btn_wake(btn_wake),
    .alm_wake(alm_wake),
    .chg_wake(chg_wake)
  );

  assign wake_any = btn_wake | alm_wake | chg_wake;
  assign tmr_lim  = (st == ST_DN_WIN) ? WIN_LIM : TMR_W'(cfg_step_dly);

  pwr_step_tmr #(.W(TMR_W)) u_tmr (
    .clk  (clk),
    .rst_n(rst_n),
    .clr  (step_clr),
    .lim  (tmr_lim),
    .done (tmr_done)
  );

  pwr_seq_fsm u_fsm (
    .clk     (clk),
    .rst_n   (rst_n),
    .wake    (wake_any),
    .bat_ok  (bat_above_boot),
    .bat_low (bat_below_crit),
    .off_req (off_req),
    .tmr_done(tmr_done),
    .st      (st),
    .step_clr(step_clr),
    .emg     (emg),
    .chk_fail(chk_fail)
  );

  assign rails       = rails_of(st);
  assign osc_en      = rails.osc;
  assign bandgap_en  = rails.bg;
  assign chg_pump_en = rails.cp;
  assign ldo_en      = rails.reg_on;
  assign dcdc_en     = rails.dcdc;
  assign on_off      = rails.on_off;
  assign sys_rst_n   = rails.rst_rel;
  assign clk_main_en = rails.clk_en;
  assign fiq_n       = ~emg;
  assign pwr_mode    = mode_of(st, emg);

endmodule

// File: rtl/pwr_seq_ctrl_chk.sv
module pwr_seq_ctrl_chk (
  input logic       clk,
  input logic       rst_n,
  input logic       off_req,
  input logic       bat_below_crit,
  input logic       osc_en,
  input logic       bandgap_en,
  input logic       chg_pump_en,
  input logic       ldo_en,
  input logic       dcdc_en,
  input logic       on_off,
  input logic       sys_rst_n,
  input logic       fiq_n,
  input logic       clk_main_en,
  input logic [2:0] pwr_mode,
  input logic       chk_fail
);
  assert_bg_needs_osc_R5: assert property (@(posedge clk) disable iff (!rst_n)
    bandgap_en |-> osc_en);
  assert_pump_needs_bg_R5: assert property (@(posedge clk) disable iff (!rst_n)
    chg_pump_en |-> bandgap_en);
  assert_onoff_needs_rails_R5: assert property (@(posedge clk) disable iff (!rst_n)
    on_off |-> (ldo_en && chg_pump_en));
  assert_release_needs_onoff_R5: assert property (@(posedge clk) disable iff (!rst_n)
    sys_rst_n |-> on_off);
  assert_clk_needs_release_R5: assert property (@(posedge clk) disable iff (!rst_n)
    clk_main_en |-> sys_rst_n);
  assert_dcdc_needs_ldo_R7: assert property (@(posedge clk) disable iff (!rst_n)
    dcdc_en |-> ldo_en);
  assert_off_req_window_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (pwr_mode == 3'd2 && off_req && !bat_below_crit) |=>
      (pwr_mode == 3'd3 && !dcdc_en && !sys_rst_n && !clk_main_en));
  assert_fiq_only_emg_R8: assert property (@(posedge clk) disable iff (!rst_n)
    !fiq_n |-> (pwr_mode == 3'd4));
  assert_osc_rise_from_off_R9: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(osc_en) |-> ($past(pwr_mode) == 3'd0));
  assert_abort_drops_bg_R6: assert property (@(posedge clk) disable iff (!rst_n)
    chk_fail |=> (!bandgap_en && osc_en && !chg_pump_en && pwr_mode == 3'd1));
  assert_mode_legal_R10: assert property (@(posedge clk) disable iff (!rst_n)
    pwr_mode <= 3'd4);
  assert_emg_priority_R11: assert property (@(posedge clk) disable iff (!rst_n)
    (pwr_mode == 3'd2 && bat_below_crit) |=> (pwr_mode == 3'd4 && !fiq_n));
endmodule

bind pwr_seq_ctrl pwr_seq_ctrl_chk u_chk (
  .clk           (clk),
  .rst_n         (rst_n),
  .off_req       (off_req),
  .bat_below_crit(bat_below_crit),
  .osc_en        (osc_en),
  .bandgap_en    (bandgap_en),
  .chg_pump_en   (chg_pump_en),
  .ldo_en        (ldo_en),
  .dcdc_en       (dcdc_en),
  .on_off        (on_off),
  .sys_rst_n     (sys_rst_n),
  .fiq_n         (fiq_n),
  .clk_main_en   (clk_main_en),
  .pwr_mode      (pwr_mode),
  .chk_fail      (chk_fail)
);

// File: tb/pwr_seq_ctrl_tb.sv
`timescale 1ns/1ps
module pwr_seq_ctrl_tb;
  localparam int DLY_W = 8;
  localparam int DEB   = 40;
  localparam int WIN   = 12;

  logic clk = 1'b0;
  logic rst_n;
  logic pwr_btn_n, alarm_in, chg_above_bat, bat_above_boot, bat_below_crit, off_req;
  logic [DLY_W-1:0] cfg_step_dly;
  logic osc_en, bandgap_en, chg_pump_en, ldo_en, dcdc_en, on_off;
  logic sys_rst_n, fiq_n, clk_main_en;
  logic [2:0] pwr_mode;

  always #10 clk = ~clk;

  pwr_seq_ctrl #(
    .DLY_W(DLY_W), .TMR_W(16), .DEB_CYC(DEB), .OFF_WIN_CYC(WIN), .SYNC_STG(2)
  ) u_dut (
    .clk(clk), .rst_n(rst_n), .pwr_btn_n(pwr_btn_n), .alarm_in(alarm_in),
    .chg_above_bat(chg_above_bat), .bat_above_boot(bat_above_boot),
    .bat_below_crit(bat_below_crit), .off_req(off_req), .cfg_step_dly(cfg_step_dly),
    .osc_en(osc_en), .bandgap_en(bandgap_en), .chg_pump_en(chg_pump_en),
    .ldo_en(ldo_en), .dcdc_en(dcdc_en), .on_off(on_off), .sys_rst_n(sys_rst_n),
    .fiq_n(fiq_n), .clk_main_en(clk_main_en), .pwr_mode(pwr_mode)
  );

  int n_cmp = 0;
  int n_bad = 0;
  int cyc = 0;
  int t_osc_r, t_osc_f, t_bg_r, t_bg_f, t_cp_r, t_reg_r, t_reg_f;
  int t_on_r, t_on_f, t_rst_r, t_rst_f, t_clk_r, t_dcdc_f, t_fiq_f, t_fiq_r, t_mode_on;
  int n_osc_r = 0;
  int n_cp_r = 0;
  logic p_osc = 0, p_bg = 0, p_cp = 0, p_reg = 0, p_on = 0, p_rst = 0, p_clk = 0;
  logic p_dcdc = 0, p_fiq = 1;
  logic [2:0] p_mode = 0;
  logic seen_dn = 0, seen_emg = 0;

  // Edge recorder, sampled away from the active edge
  always @(negedge clk) begin
    cyc++;
    if (osc_en && !p_osc) begin t_osc_r = cyc; n_osc_r++; end
    if (!osc_en && p_osc) t_osc_f = cyc;
    if (bandgap_en && !p_bg) t_bg_r = cyc;
    if (!bandgap_en && p_bg) t_bg_f = cyc;
    if (chg_pump_en && !p_cp) begin t_cp_r = cyc; n_cp_r++; end
    if (ldo_en && !p_reg) t_reg_r = cyc;
    if (!ldo_en && p_reg) t_reg_f = cyc;
    if (on_off && !p_on) t_on_r = cyc;
    if (!on_off && p_on) t_on_f = cyc;
    if (sys_rst_n && !p_rst) t_rst_r = cyc;
    if (!sys_rst_n && p_rst) t_rst_f = cyc;
    if (clk_main_en && !p_clk) t_clk_r = cyc;
    if (!dcdc_en && p_dcdc) t_dcdc_f = cyc;
    if (!fiq_n && p_fiq) t_fiq_f = cyc;
    if (fiq_n && !p_fiq) t_fiq_r = cyc;
    if (pwr_mode == 3'd2 && p_mode != 3'd2) t_mode_on = cyc;
    if (pwr_mode == 3'd3) seen_dn = 1;
    if (pwr_mode == 3'd4) seen_emg = 1;
    p_osc = osc_en; p_bg = bandgap_en; p_cp = chg_pump_en; p_reg = ldo_en;
    p_on = on_off; p_rst = sys_rst_n; p_clk = clk_main_en; p_dcdc = dcdc_en;
    p_fiq = fiq_n; p_mode = pwr_mode;
  end

  task automatic check(input string req, input int act, input int exp);
    n_cmp++;
    if (act != exp) begin
      n_bad++;
      $display("FAIL %s: actual %0d expected %0d", req, act, exp);
    end
  endtask

  task automatic wait_mode(input int m, input int lim);
    int n = 0;
    while (int'(pwr_mode) != m && n < lim) begin @(negedge clk); n++; end
    check("wait for mode", int'(pwr_mode), m);
  endtask

  task automatic wait_leave(input int m, input int lim);
    int n = 0;
    while (int'(pwr_mode) == m && n < lim) begin @(negedge clk); n++; end
    n_cmp++;
    if (int'(pwr_mode) == m) begin
      n_bad++;
      $display("FAIL leave mode: actual %0d expected not %0d", pwr_mode, m);
    end
  endtask

  // src 0 = button (R2), 1 = alarm (R3), 2 = charger (R4)
  task automatic run_up(input int dly, input int src);
    int d = dly + 1;
    cfg_step_dly = DLY_W'(dly);
    case (src)
      0: begin pwr_btn_n = 0; repeat (DEB + 8) @(negedge clk); pwr_btn_n = 1; end
      1: begin alarm_in = 1; repeat (3) @(negedge clk); alarm_in = 0; end
      default: chg_above_bat = 1;
    endcase
    wait_mode(2, 4000);
    repeat (2) @(negedge clk);
    if (src == 0) check("R2 button wake reaches on", int'(pwr_mode), 2);
    if (src == 1) check("R3 alarm wake reaches on", int'(pwr_mode), 2);
    if (src == 2) check("R4 charger wake reaches on", int'(pwr_mode), 2);
    check("R5 osc->bandgap", t_bg_r - t_osc_r, d);
    check("R5 bandgap->pump across check", t_cp_r - t_bg_r, 2 * d);
    check("R5 pump->regulators", t_reg_r - t_cp_r, d);
    check("R5 regulators->on_off", t_on_r - t_reg_r, d);
    check("R5 on_off->reset release", t_rst_r - t_on_r, d);
    check("R5 release->main clock", t_clk_r - t_rst_r, d);
    check("R5 main clock->on mode", t_mode_on - t_clk_r, d);
    check("R5 dcdc on with regulators", int'(dcdc_en), 1);
  endtask

  task automatic run_down(input int dly, input bit emg);
    int d = dly + 1;
    seen_dn = 0; seen_emg = 0;
    if (emg) bat_below_crit = 1; else off_req = 1;
    wait_leave(2, 10);
    if (emg) begin
      check("R8 fiq low first", int'(fiq_n), 0);
      check("R10 emergency code", int'(pwr_mode), 4);
      check("R8 pump still on while fiq low", int'(chg_pump_en), 1);
    end else begin
      check("R10 powering-down code", int'(pwr_mode), 3);
      check("R7 dcdc off in window", int'(dcdc_en), 0);
    end
    bat_below_crit = 0; off_req = 0;
    wait_mode(0, 4000);
    repeat (2) @(negedge clk);
    if (emg) begin
      check("R8 fiq->dcdc off", t_dcdc_f - t_fiq_f, d);
      check("R8 fiq release with osc off", t_fiq_r, t_osc_f);
      check("R10 no plain down code in emergency", int'(seen_dn), 0);
    end else begin
      check("R10 no emergency code", int'(seen_emg), 0);
    end
    check("R7 reset with dcdc", t_rst_f, t_dcdc_f);
    check("R7 window length", t_on_f - t_dcdc_f, WIN);
    check("R7 on_off->regulators off", t_reg_f - t_on_f, d);
    check("R7 regulators->bandgap off", t_bg_f - t_reg_f, d);
    check("R7 bandgap->osc off", t_osc_f - t_bg_f, d);
  endtask

  task automatic run_abort(input int dly);
    int d = dly + 1;
    int cp0 = n_cp_r;
    cfg_step_dly = DLY_W'(dly);
    bat_above_boot = 0;
    alarm_in = 1; repeat (3) @(negedge clk); alarm_in = 0;
    wait_leave(0, 20);
    wait_mode(0, 4000);
    repeat (2) @(negedge clk);
    check("R6 bandgap off after check", t_bg_f - t_bg_r, 2 * d);
    check("R6 osc off after bandgap", t_osc_f - t_bg_f, d);
    check("R6 pump never enabled", n_cp_r - cp0, 0);
    bat_above_boot = 1;
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    n_bad++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end

  initial begin
    int dlys[6] = '{0, 1, 2, 3, 5, 7};
    int osc0;
    rst_n = 0; pwr_btn_n = 1; alarm_in = 0; chg_above_bat = 0;
    bat_above_boot = 1; bat_below_crit = 0; off_req = 0; cfg_step_dly = '0;
    repeat (3) @(negedge clk);
    check("R1 rails in reset",
          int'({osc_en, bandgap_en, chg_pump_en, ldo_en, dcdc_en, on_off, clk_main_en}), 0);
    check("R1 reset and fiq", int'({sys_rst_n, fiq_n}), 1);
    check("R1 mode off", int'(pwr_mode), 0);
    rst_n = 1;
    repeat (3) @(negedge clk);

    // R2: press shorter than the debounce time
    pwr_btn_n = 0; repeat (DEB - 5) @(negedge clk); pwr_btn_n = 1;
    repeat (20) @(negedge clk);
    check("R2 short press ignored", int'(pwr_mode), 0);
    check("R2 short press osc stays off", int'(osc_en), 0);

    // Delay sweep with rotating wake source and teardown kind
    for (int k = 0; k < 6; k++) begin
      run_up(dlys[k], k % 3);
      run_down(dlys[k], (k % 2) == 1);
      if (k % 3 == 2) begin
        repeat (40) @(negedge clk);
        check("R4 held charger no rewake", int'(pwr_mode), 0);
        chg_above_bat = 0;
        repeat (5) @(negedge clk);
      end
    end

    // R6: failed boot check at two delays
    run_abort(0);
    run_abort(3);

    // R9 / R3: wake events while running, alarm held high
    osc0 = n_osc_r;
    cfg_step_dly = 8'd2;
    alarm_in = 1;
    repeat (5) @(negedge clk);
    chg_above_bat = 1;
    wait_mode(2, 4000);
    chg_above_bat = 0;
    pwr_btn_n = 0; repeat (DEB + 8) @(negedge clk); pwr_btn_n = 1;
    check("R9 wake while on ignored", int'(pwr_mode), 2);
    check("R9 single osc rise", n_osc_r - osc0, 1);
    off_req = 1; wait_leave(2, 10); off_req = 0;
    wait_mode(0, 4000);
    repeat (40) @(negedge clk);
    check("R9 no latched wake after off", int'(pwr_mode), 0);
    check("R3 held alarm no rewake", n_osc_r - osc0, 1);
    alarm_in = 0;
    repeat (5) @(negedge clk);

    // R11: emergency beats shutdown request
    run_up(1, 1);
    bat_below_crit = 1; off_req = 1;
    wait_leave(2, 10);
    check("R11 emergency wins", int'(pwr_mode), 4);
    check("R11 fiq low", int'(fiq_n), 0);
    bat_below_crit = 0; off_req = 0;
    wait_mode(0, 4000);
    repeat (3) @(negedge clk);
    check("R8 fiq high once off", int'(fiq_n), 1);

    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end
endmodule